// File: doc/BRIEF.md
# Edge-Triggered Reset Controller

This block holds a small bank of 32-bit reset control registers and turns changes of the stored reset bits into actions on the reset targets. A register write is compared with the value already held. Only a bit whose value differs between the two causes an action. The new value is then stored and can be read back.

Processor cores receive level-style control. Setting a core's reset bit halts the core and powers it down. Clearing the bit brings the core back up with a fresh reset. Ordinary peripherals receive a one-clock cold-reset pulse whenever their bit flips, in either direction. One shared register bit controls a whole group of DMA channels, so a change of that bit pulses every channel in the same cycle. A peripheral slot can be built without a target. Its bit is then stored, but a change of it causes no action.

The register map is as follows. Index 0 is the core register: one reset bit per core from bit 0 upward, with the remaining kept bits stored and no target behind them. Index 1 is the DMA group register. Indices 2 and up are the single-bit peripheral registers, with peripheral j at index 2+j. Read data is combinational from the address.

Top module: `edge_rst_ctrl`

## Requirements
- R1: After controller reset, the core register reads 0x17 and every other register reads 0x1. All cores are halted (core_run low) and no pulse output is active.
- R2: A write to an existing register stores the written value with the reserved bits forced to zero, and the stored value reads back. For the core register the kept bits are 0, 1, 2 and 4 (mask 0x17), and bit 3 and bits 5 to 31 read as zero. For all other registers only bit 0 is kept.
- R3: A write that changes core i's bit (bit i of index 0) from 0 to 1 drives core_run[i] low from the next cycle and produces no core_boot pulse.
- R4: A write that changes core i's bit from 1 to 0 drives core_run[i] high from the next cycle. It also raises core_boot[i] for exactly that one cycle.
- R5: A write whose value equals the stored value of a reset bit produces no action for that bit.
- R6: A write that changes an attached peripheral's bit (bit 0 of index 2+j) in either direction raises periph_rst[j] for exactly one cycle, in the cycle after the write.
- R7: A change of the DMA group bit (bit 0 of index 1) raises every dma_rst channel together for exactly one cycle.
- R8: A peripheral slot whose ATTACHED bit is 0 stores and returns its written bit, but its periph_rst output never pulses.
- R9: Asserting the controller reset restores all reset values and produces no pulse, even when stored bits differ from their reset values.
- R10: A write to an address at or above the number of registers changes nothing, and a read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | AW | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| core_run | output | NCORE | High while the core is powered and running |
| core_boot | output | NCORE | One-cycle restart-with-reset pulse per core |
| dma_rst | output | NDMA | One-cycle cold-reset pulse per DMA channel |
| periph_rst | output | NPERIPH | One-cycle cold-reset pulse per peripheral |

## Verification
The hardest cases to reach are the ones where the write value and the stored value disagree in some bits and agree in others within the same write. A core register write can halt one core, restart another and leave a third bit untouched. A reset bit can also be rewritten with its current value. The directed phase steps the core register through values that combine these cases. It also rewrites the DMA and peripheral bits with both equal and unequal values, using data whose upper bits are all set. A long random phase then mixes writes across every index, including unmapped ones. A behavioural model tracks the stored value and compares every output on every clock. A final controller reset is applied while cores are running, to show that no action comes out of it.

// File: rtl/erc_pkg.sv
package erc_pkg;
   localparam int DW = 32;

   typedef enum logic [1:0] {
      RK_CORE,
      RK_GROUP,
      RK_SINGLE
   } reg_kind_e;

   function automatic reg_kind_e kind_of(input int idx);
      if (idx == 0) return RK_CORE;
      if (idx == 1) return RK_GROUP;
      return RK_SINGLE;
   endfunction

   function automatic logic [DW-1:0] keep_of(input int idx, input logic [DW-1:0] core_keep);
      return (kind_of(idx) == RK_CORE) ? core_keep : {{(DW-1){1'b0}}, 1'b1};
   endfunction

   function automatic logic [DW-1:0] init_of(input int idx, input logic [DW-1:0] core_rst,
                                             input logic [DW-1:0] core_keep);
      return (kind_of(idx) == RK_CORE) ? (core_rst & core_keep) : {{(DW-1){1'b0}}, 1'b1};
   endfunction
endpackage

// File: rtl/erc_regfile.sv
module erc_regfile
   import erc_pkg::*;
#(
   parameter int          NCORE     = 2,
   parameter int          NPERIPH   = 12,
   parameter int          AW        = 4,
   parameter logic [31:0] CORE_RST  = 32'h17,
   parameter logic [31:0] CORE_KEEP = 32'h17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rdata,
   output logic               hit_core,
   output logic               hit_grp,
   output logic [NPERIPH-1:0] hit_per,
   output logic [NCORE-1:0]   core_bits,
   output logic               grp_bit,
   output logic [NPERIPH-1:0] per_bits
);
   localparam int NREG = NPERIPH + 2;

   logic [DW-1:0] store_q [NREG];
   logic [NREG-1:0] hit;

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      localparam logic [DW-1:0] KEEP = keep_of(k, CORE_KEEP);
      localparam logic [DW-1:0] INIT = init_of(k, CORE_RST, CORE_KEEP);

      assign hit[k] = we && (addr == AW'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      store_q[k] <= INIT;
         else if (hit[k]) store_q[k] <= wdata & KEEP;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NREG; k++) begin
         if (addr == AW'(k)) rdata = store_q[k];
      end
   end

   assign hit_core  = hit[0];
   assign hit_grp   = hit[1];
   assign core_bits = store_q[0][NCORE-1:0];
   assign grp_bit   = store_q[1][0];

   for (genvar j = 0; j < NPERIPH; j++) begin : g_out
      assign hit_per[j]  = hit[j+2];
      assign per_bits[j] = store_q[j+2][0];
   end
endmodule

// File: rtl/erc_core_seq.sv
module erc_core_seq #(
   parameter int          NCORE    = 2,
   parameter logic [31:0] CORE_RST = 32'h17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [NCORE-1:0] old_bits,
   input  logic [NCORE-1:0] new_bits,
   output logic [NCORE-1:0] run,
   output logic [NCORE-1:0] boot
);
   for (genvar i = 0; i < NCORE; i++) begin : g_core
      logic go_off, go_on;
      assign go_off = hit && !old_bits[i] &&  new_bits[i];
      assign go_on  = hit &&  old_bits[i] && !new_bits[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run[i]  <= ~CORE_RST[i];
            boot[i] <= 1'b0;
         end else begin
            boot[i] <= go_on;
            if (go_off)     run[i] <= 1'b0;
            else if (go_on) run[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/erc_pulse_seq.sv
module erc_pulse_seq #(
   parameter int                NDMA     = 8,
   parameter int                NPERIPH  = 12,
   parameter logic [NPERIPH-1:0] ATTACHED = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_grp,
   input  logic               grp_old,
   input  logic [NPERIPH-1:0] hit_per,
   input  logic [NPERIPH-1:0] per_old,
   input  logic               new_bit,
   output logic [NDMA-1:0]    dma_rst,
   output logic [NPERIPH-1:0] periph_rst
);
   logic grp_flip;
   assign grp_flip = hit_grp && (grp_old != new_bit);

   for (genvar c = 0; c < NDMA; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dma_rst[c] <= 1'b0;
         else        dma_rst[c] <= grp_flip;
      end
   end

   for (genvar j = 0; j < NPERIPH; j++) begin : g_per
      if (ATTACHED[j]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) periph_rst[j] <= 1'b0;
            else        periph_rst[j] <= hit_per[j] && (per_old[j] != new_bit);
         end
      end else begin : g_open
         logic unused_in;
         assign unused_in     = hit_per[j] ^ per_old[j];
         assign periph_rst[j] = 1'b0;
      end
   end
endmodule

// File: rtl/edge_rst_ctrl.sv
module edge_rst_ctrl
   import erc_pkg::*;
#(
   parameter int                 NCORE     = 2,
   parameter int                 NDMA      = 8,
   parameter int                 NPERIPH   = 12,
   parameter logic [NPERIPH-1:0] ATTACHED  = 12'h03F,
   parameter logic [31:0]        CORE_RST  = 32'h17,
   parameter logic [31:0]        CORE_KEEP = 32'h17,
   parameter int                 AW        = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [AW-1:0]      reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic [NCORE-1:0]   core_run,
   output logic [NCORE-1:0]   core_boot,
   output logic [NDMA-1:0]    dma_rst,
   output logic [NPERIPH-1:0] periph_rst
);
   localparam int NREG = NPERIPH + 2;

   if (NCORE < 1 || NCORE > 16) begin : g_bad_ncore
      $error("NCORE out of range");
   end
   if (NDMA < 1) begin : g_bad_ndma
      $error("NDMA must be at least 1");
   end
   if (NPERIPH < 1) begin : g_bad_nper
      $error("NPERIPH must be at least 1");
   end
   if ($clog2(NREG) > AW) begin : g_bad_aw
      $error("AW too narrow for the register count");
   end
   if ((CORE_KEEP[NCORE-1:0] & {NCORE{1'b1}}) != {NCORE{1'b1}}) begin : g_bad_keep
      $error("CORE_KEEP must keep every core bit");
   end

   logic               hit_core, hit_grp;
   logic [NPERIPH-1:0] hit_per;
   logic [NCORE-1:0]   core_bits;
   logic               grp_bit;
   logic [NPERIPH-1:0] per_bits;

   erc_regfile #(
      .NCORE(NCORE), .NPERIPH(NPERIPH), .AW(AW),
      .CORE_RST(CORE_RST), .CORE_KEEP(CORE_KEEP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .hit_core(hit_core), .hit_grp(hit_grp), .hit_per(hit_per),
      .core_bits(core_bits), .grp_bit(grp_bit), .per_bits(per_bits)
   );

   erc_core_seq #(.NCORE(NCORE), .CORE_RST(CORE_RST)) u_cores (
      .clk(clk), .rst_n(rst_n), .hit(hit_core),
      .old_bits(core_bits), .new_bits(reg_wdata[NCORE-1:0]),
      .run(core_run), .boot(core_boot)
   );

   erc_pulse_seq #(.NDMA(NDMA), .NPERIPH(NPERIPH), .ATTACHED(ATTACHED)) u_pulses (
      .clk(clk), .rst_n(rst_n), .hit_grp(hit_grp), .grp_old(grp_bit),
      .hit_per(hit_per), .per_old(per_bits), .new_bit(reg_wdata[0]),
      .dma_rst(dma_rst), .periph_rst(periph_rst)
   );
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
   parameter int                 NCORE    = 2,
   parameter int                 NDMA     = 8,
   parameter int                 NPERIPH  = 12,
   parameter logic [NPERIPH-1:0] ATTACHED = 12'h03F
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NCORE-1:0]   core_run,
   input logic [NCORE-1:0]   core_boot,
   input logic [NCORE-1:0]   core_bits,
   input logic [NDMA-1:0]    dma_rst,
   input logic               grp_bit,
   input logic [NPERIPH-1:0] periph_rst,
   input logic [NPERIPH-1:0] per_bits
);
   for (genvar i = 0; i < NCORE; i++) begin : g_core_chk
      p_run_vs_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
         core_run[i] != core_bits[i]);
      p_boot_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
         core_boot[i] |=> !core_boot[i]);
      p_boot_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
         core_boot[i] |-> (core_run[i] && !core_bits[i]));
   end

   p_group_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rst == '0) || (dma_rst == '1));
   p_group_on_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rst[0] |-> (grp_bit != $past(grp_bit)));

   for (genvar j = 0; j < NPERIPH; j++) begin : g_per_chk
      p_pulse_on_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
         periph_rst[j] |-> (per_bits[j] != $past(per_bits[j])));
      if (ATTACHED[j]) begin : g_att
         p_flip_gives_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (per_bits[j] != $past(per_bits[j])) |-> periph_rst[j]);
      end
   end
endmodule

bind edge_rst_ctrl erc_checker #(
   .NCORE(NCORE), .NDMA(NDMA), .NPERIPH(NPERIPH), .ATTACHED(ATTACHED)
) u_erc_checker (
   .clk(clk), .rst_n(rst_n), .core_run(core_run), .core_boot(core_boot),
   .core_bits(core_bits), .dma_rst(dma_rst), .grp_bit(grp_bit),
   .periph_rst(periph_rst), .per_bits(per_bits)
);

// File: tb/edge_rst_ctrl_bench.sv
module edge_rst_ctrl_bench;
   localparam int CLK_P   = 10;
   localparam int NCORE   = 2;
   localparam int NDMA    = 8;
   localparam int NPER    = 12;
   localparam int NREG    = NPER + 2;
   localparam int AW      = 4;
   localparam logic [NPER-1:0] ATT = 12'h03F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCORE-1:0] core_run, core_boot;
   logic [NDMA-1:0] dma_rst;
   logic [NPER-1:0] periph_rst;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;
   string cur_req = "R1";

   always #(CLK_P/2) clk = ~clk;

   edge_rst_ctrl u_edge_rst_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_run(core_run),
      .core_boot(core_boot), .dma_rst(dma_rst), .periph_rst(periph_rst)
   );

   // behavioural reference model
   logic [31:0] m_reg [NREG];
   logic [NCORE-1:0] m_run, m_boot;
   logic m_dma;
   logic [NPER-1:0] m_per;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reg[0] = 32'h17;
         for (int k = 1; k < NREG; k++) m_reg[k] = 32'h1;
         m_run = '0; m_boot = '0; m_dma = 1'b0; m_per = '0;
      end else begin
         m_boot = '0; m_dma = 1'b0; m_per = '0;
         if (reg_we && int'(reg_addr) < NREG) begin
            int a;
            logic [31:0] nv;
            a = int'(reg_addr);
            if (a == 0) begin
               nv = reg_wdata & 32'h17;
               for (int i = 0; i < NCORE; i++) begin
                  if (!m_reg[0][i] && nv[i]) m_run[i] = 1'b0;
                  if (m_reg[0][i] && !nv[i]) begin m_run[i] = 1'b1; m_boot[i] = 1'b1; end
               end
            end else begin
               nv = reg_wdata & 32'h1;
               if (nv != m_reg[a]) begin
                  if (a == 1) m_dma = 1'b1;
                  else if (ATT[a-2]) m_per[a-2] = 1'b1;
               end
            end
            m_reg[a] = nv;
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("R2 reg_rdata",  reg_rdata, (int'(reg_addr) < NREG) ? m_reg[reg_addr] : 32'h0);
         chk("R3 core_run",   32'(core_run), 32'(m_run));
         chk("R4 core_boot",  32'(core_boot), 32'(m_boot));
         chk("R7 dma_rst",    32'(dma_rst), m_dma ? 32'hFF : 32'h0);
         chk("R6 periph_rst", 32'(periph_rst), 32'(m_per));
      end
   end

   task automatic step(input logic we, input int a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = we; reg_addr = AW'(a); reg_wdata = d;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      step(1'b1, a, d);
      step(1'b0, a, 32'h0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: got hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cur_req = "R1";
      for (int a = 0; a < 16; a++) step(1'b0, a, 32'h0);

      cur_req = "R4";   wr(0, 32'h0000_0014);   // both cores restart
      cur_req = "R5";   wr(0, 32'h0000_0014);   // same value, no action
      cur_req = "R3";   wr(0, 32'h0000_0001);   // core0 halts
      cur_req = "R2";   wr(0, 32'hFFFF_FFFF);   // stores 0x17, core1 halts
      cur_req = "R4";   wr(0, 32'h0000_0016);   // core0 restarts, core1 held

      cur_req = "R7";   wr(1, 32'h0000_0000);
      cur_req = "R5";   wr(1, 32'hFFFF_FFFE);
      cur_req = "R7";   wr(1, 32'hFFFF_FFFF);

      for (int j = 0; j < NPER; j++) begin
         cur_req = ATT[j] ? "R6" : "R8";
         wr(j + 2, 32'hFFFF_FFFE);
         wr(j + 2, 32'h0000_0000);
         wr(j + 2, 32'h8000_0001);
      end

      cur_req = "R10";
      wr(14, 32'hFFFF_FFFF);
      wr(15, 32'h0000_0000);
      for (int a = 0; a < 16; a++) step(1'b0, a, 32'h0);

      cur_req = "R2";
      for (int n = 0; n < 1500; n++) begin
         step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)), $urandom);
      end
      step(1'b0, 0, 32'h0);

      cur_req = "R9";
      wr(0, 32'h0);
      wr(2, 32'h0);
      wr(1, 32'h0);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int a = 0; a < NREG; a++) step(1'b0, a, 32'h0);
      step(1'b0, 0, 32'h0);

      @(posedge clk); #1;
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule